// File: doc/BRIEF.md
# Manchester Line Transmitter with Selectable Idle

This block turns a serial NRZ bit stream into a Manchester-coded pair of complementary line signals. A controller raises a transmit request and presents one data bit per bit cell. For as long as the request is held, every bit goes out as two half-cells. The transition in the middle of the cell carries the data value. When the request falls, the current cell is finished and the pair drops into one of two idle patterns, chosen by a configuration bit.

Timing comes from a system clock and a half-cell clock enable, `half_ce`, that pulses once per half bit cell. At the nominal 10 Mb/s line rate, that is one pulse every 50 ns. The block has three states. `ST_IDLE` drives the idle pattern. `ST_FIRST` drives the first half-cell of a bit. `ST_SECOND` drives the second half-cell. There are four transitions, each taken only on a `half_ce` pulse:

- `ST_IDLE` to `ST_FIRST` when the request is high; the data bit is captured at this point.
- `ST_FIRST` to `ST_SECOND`, taken unconditionally.
- `ST_SECOND` to `ST_FIRST` when the request is still high; the next data bit is captured at this point.
- `ST_SECOND` to `ST_IDLE` when the request is low.

Top module: `manchester_tx`

## Requirements
- R1: After reset the block is idle and, with `idle_hi_sel` low, both lines are 0.
- R2: A data bit of 1 is sent as `line_p` low for the first half-cell and high for the second.
- R3: A data bit of 0 is sent as `line_p` high for the first half-cell and low for the second.
- R4: While a cell is being sent, `line_n` is always the complement of `line_p`.
- R5: `tx_req` is looked at only on a cell boundary. A request dropped during a cell still lets that cell finish both halves.
- R6: Idle with `idle_hi_sel` = 0 gives zero differential, with both lines at 0.
- R7: Idle with `idle_hi_sel` = 1 gives a logical HIGH, with `line_p` = 1 and `line_n` = 0.
- R8: `nrz_bit` is captured only on the `half_ce` pulse that starts a cell. Changes at any other time have no effect on the lines.
- R9: The state and the lines change only on clock edges where `half_ce` is 1. While `half_ce` is low, an active transmission holds its level.
- R10: While `tx_req` stays high, cells follow one another with no idle half-cell between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_ce | input | 1 | One-cycle pulse that marks each half-cell boundary |
| tx_req | input | 1 | Transmit request, sampled at cell boundaries |
| nrz_bit | input | 1 | Serial NRZ data bit, captured at the start of a cell |
| idle_hi_sel | input | 1 | Idle pattern select: 0 gives zero differential, 1 gives logical HIGH |
| line_p | output | 1 | Positive line of the pair |
| line_n | output | 1 | Negative line of the pair |

## Verification
The assertions assume three things about the inputs. First, `half_ce` is a single-cycle pulse. Second, `idle_hi_sel` changes only while the block is idle. Third, the lines move only at half-cell edges. The bench respects all three. It produces `half_ce` itself, one pulse in every four clocks, or holds it low on purpose to stall the block. It changes `tx_req` only on pulse cycles, and it switches the idle select only between frames. It toggles `nrz_bit` freely in the cycles between pulses. This shows that off-boundary changes are ignored, without breaking any assumption.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } tx_state_e;
endpackage

// File: rtl/mtx_cell_fsm.sv
module mtx_cell_fsm
    import mtx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      half_ce,
    input  logic      tx_req,
    input  logic      nrz_bit,
    output tx_state_e state,
    output logic      cell_bit
);
    tx_state_e state_nx;
    logic      cell_bit_nx;

    // State register and captured data bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cell_bit <= 1'b0;
        end else if (half_ce) begin
            state    <= state_nx;
            cell_bit <= cell_bit_nx;
        end
    end

    // Transitions; a new bit is captured only when a cell starts
    always_comb begin
        state_nx    = state;
        cell_bit_nx = cell_bit;
        unique case (state)
            ST_IDLE: begin
                if (tx_req) begin
                    state_nx    = ST_FIRST;
                    cell_bit_nx = nrz_bit;
                end
            end
            ST_FIRST: begin
                state_nx = ST_SECOND;
            end
            ST_SECOND: begin
                if (tx_req) begin
                    state_nx    = ST_FIRST;
                    cell_bit_nx = nrz_bit;
                end else begin
                    state_nx = ST_IDLE;
                end
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/mtx_line_encoder.sv
module mtx_line_encoder
    import mtx_pkg::*;
#(
    parameter logic ONE_LOW_FIRST = 1'b1,
    parameter logic ZD_LEVEL      = 1'b0
) (
    input  tx_state_e state,
    input  logic      cell_bit,
    input  logic      idle_hi_sel,
    output logic      line_p,
    output logic      line_n
);
    logic first_lvl;

    assign first_lvl = cell_bit ^ ONE_LOW_FIRST;

    always_comb begin
        line_p = ZD_LEVEL;
        line_n = ZD_LEVEL;
        unique case (state)
            ST_FIRST: begin
                line_p = first_lvl;
                line_n = ~first_lvl;
            end
            ST_SECOND: begin
                line_p = ~first_lvl;
                line_n = first_lvl;
            end
            ST_IDLE: begin
                if (idle_hi_sel) begin
                    line_p = 1'b1;
                    line_n = 1'b0;
                end
            end
            default: begin
                line_p = ZD_LEVEL;
                line_n = ZD_LEVEL;
            end
        endcase
    end
endmodule

// File: rtl/manchester_tx.sv
module manchester_tx
    import mtx_pkg::*;
#(
    parameter logic ONE_LOW_FIRST = 1'b1,
    parameter logic ZD_LEVEL      = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic half_ce,
    input  logic tx_req,
    input  logic nrz_bit,
    input  logic idle_hi_sel,
    output logic line_p,
    output logic line_n
);
    tx_state_e tx_state;
    logic      cell_bit;

    mtx_cell_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_ce  (half_ce),
        .tx_req   (tx_req),
        .nrz_bit  (nrz_bit),
        .state    (tx_state),
        .cell_bit (cell_bit)
    );

    mtx_line_encoder #(
        .ONE_LOW_FIRST (ONE_LOW_FIRST),
        .ZD_LEVEL      (ZD_LEVEL)
    ) u_enc (
        .state       (tx_state),
        .cell_bit    (cell_bit),
        .idle_hi_sel (idle_hi_sel),
        .line_p      (line_p),
        .line_n      (line_n)
    );
endmodule

// File: rtl/mtx_tx_checker.sv
module mtx_tx_checker
    import mtx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      half_ce,
    input logic      idle_hi_sel,
    input tx_state_e state,
    input logic      line_p,
    input logic      line_n
);
    a_r4_lines_differ: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (line_p != line_n));

    a_r6_zero_diff: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !idle_hi_sel) |-> (line_p == line_n));

    a_r7_mark_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && idle_hi_sel) |-> (line_p && !line_n));

    a_r2_mid_transition: assert property (@(posedge clk) disable iff (!rst_n)
        (half_ce && state == ST_FIRST) |=> (line_p != $past(line_p)));

    a_r5_cell_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (half_ce && state == ST_FIRST) |=> (state == ST_SECOND));

    a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!half_ce && state != ST_IDLE) |=> ($stable(state) && $stable(line_p)));
endmodule

bind manchester_tx mtx_tx_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .half_ce     (half_ce),
    .idle_hi_sel (idle_hi_sel),
    .state       (tx_state),
    .line_p      (line_p),
    .line_n      (line_n)
);

// File: tb/tb_manchester_tx.sv
`timescale 1ns/1ps
module tb_manchester_tx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic half_ce = 1'b0;
    logic tx_req = 1'b0;
    logic nrz_bit = 1'b0;
    logic idle_hi_sel = 1'b0;
    logic line_p, line_n;

    int checks = 0;
    int fails  = 0;
    bit jitter = 1'b0;
    string scen = "R1";

    // Reference model state
    logic q[$];
    logic exp_active = 1'b0;
    logic exp_lvl = 1'b0;

    always #4 clk = ~clk;

    manchester_tx dut (
        .clk(clk), .rst_n(rst_n), .half_ce(half_ce), .tx_req(tx_req),
        .nrz_bit(nrz_bit), .idle_hi_sel(idle_hi_sel),
        .line_p(line_p), .line_n(line_n)
    );

    // Behavioural model: every cell becomes two queued half-cell levels
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            exp_active <= 1'b0;
        end else if (half_ce) begin
            if (q.size() > 0) begin
                exp_lvl    <= q.pop_front();
                exp_active <= 1'b1;
            end else if (tx_req) begin
                exp_lvl    <= ~nrz_bit;
                q.push_back(nrz_bit);
                exp_active <= 1'b1;
            end else begin
                exp_active <= 1'b0;
            end
        end
    end

    // Compare on every clock, away from the edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            logic ep, en;
            if (exp_active) begin
                ep = exp_lvl; en = ~exp_lvl;
            end else begin
                ep = idle_hi_sel; en = 1'b0;
            end
            checks++;
            if (line_p !== ep || line_n !== en) begin
                fails++;
                $display("FAIL %s: line_p/line_n = %b%b expected %b%b at %0t",
                         scen, line_p, line_n, ep, en, $time);
            end
            if (exp_active) begin
                checks++;
                if (line_p === line_n) begin
                    fails++;
                    $display("FAIL R4: line_p/line_n = %b%b expected complementary", line_p, line_n);
                end
            end
        end
    end

    task automatic step(input logic req, input logic b);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            half_ce = 1'b0;
            if (jitter) nrz_bit = ~nrz_bit;
        end
        @(negedge clk);
        half_ce = 1'b1;
        tx_req  = req;
        nrz_bit = b;
    endtask

    task automatic send_bit(input logic b);
        step(1'b1, b);
        step(1'b1, ~b);
    endtask

    task automatic finish_frame();
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic stall(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            half_ce = 1'b0;
            if (jitter) nrz_bit = ~nrz_bit;
        end
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        checks++;
        if (line_p !== 1'b0 || line_n !== 1'b0) begin
            fails++;
            $display("FAIL R1: reset lines %b%b expected 00", line_p, line_n);
        end
        scen = "R1";
        stall(6);

        scen = "R2";
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        finish_frame();

        scen = "R3";
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        finish_frame();

        scen = "R10";
        for (int i = 0; i < 8; i++) send_bit(logic'(i % 2 == 0 || i == 5));
        finish_frame();

        scen = "R6";
        idle_hi_sel = 1'b0;
        stall(10);

        scen = "R7";
        idle_hi_sel = 1'b1;
        stall(6);
        send_bit(1'b1);
        send_bit(1'b0);
        finish_frame();
        stall(6);
        idle_hi_sel = 1'b0;
        stall(2);

        scen = "R5";
        step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        finish_frame();
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        finish_frame();

        scen = "R8";
        jitter = 1'b1;
        for (int i = 0; i < 6; i++) send_bit(logic'(i % 3 == 0));
        finish_frame();
        jitter = 1'b0;

        scen = "R9";
        step(1'b1, 1'b1);
        stall(20);
        step(1'b1, 1'b0);
        stall(15);
        step(1'b1, 1'b0);
        stall(9);
        step(1'b0, 1'b0);
        finish_frame();
        stall(4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule